// File: doc/BRIEF.md
# Cascadable Periodic Countdown Timer Bank

The block holds four down-counting periodic timers, each 32 bits wide, behind a simple synchronous register port. Every channel counts down on cycles where the shared `tick` strobe is high. When it passes zero it reloads its load value, sets a sticky timeout flag and keeps running. All channel flags, each gated by that channel's interrupt enable, are ORed onto a single `irq` line.

Any channel other than channel 0 can be cascaded onto the channel numbered one below it. A cascaded channel then steps only when that lower channel expires, so the pair forms a wider counter, and the flag of the upper channel marks expiry of the whole pair. For the pair made of channels 0 and 1, a 64-bit lifetime value can be read in two halves. Reading the high half latches the low half in the same cycle, so the two halves stay consistent.

A global halt bit comes out of reset set and stops every channel; software clears it before any timer can run. Registers use word addresses. Channel `c` owns addresses `4c+0` (load value), `4c+1` (current count, read-only), `4c+2` (control: bit0 run, bit1 interrupt enable, bit2 cascade) and `4c+3` (flag, bit0, write 1 to clear). Address 16 holds the halt bit in bit0, address 17 is the lifetime high half and address 18 the lifetime low half. Read data appears on `rdata` one cycle after `rd_en`.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset every load, control and flag register reads 0, the halt register (address 16) reads 1 and `irq` is low.
- R2: An unhalted, running, uncascaded channel with load value N counts N, N-1, … 0 on successive ticks. On the (N+1)th tick it sets its flag (bit0 of address 4c+3) and its count returns to N.
- R3: A running uncascaded channel does not change its count on cycles where `tick` is low.
- R4: A timeout flag is set on expiry and stays set. Writing 1 to bit0 of the flag register clears it; writing 0 leaves it unchanged.
- R5: `irq` is high exactly when some channel has its flag set and its interrupt enable (control bit1) set.
- R6: A channel with its cascade bit (control bit2) set steps only on cycles where the channel below it expires; ticks alone do not change it.
- R7: Setting the cascade bit on channel 0 has no effect: it still counts on ticks.
- R8: While the halt bit (address 16 bit0) is 1, no channel counts or sets its flag. When the halt bit is cleared, a channel whose run bit is set is loaded with its load value.
- R9: Writing 0 to a control register stops the channel (control reads 0, no further flags). Setting the run bit again loads the count from the load value.
- R10: Writing a load value while a channel runs does not change the current count; the new value is used at the next reload.
- R11: Reading address 17 returns the count of channel 1 and latches the count of channel 0 in that same cycle. The next read of address 18 returns the latched value, even if channel 0 reloaded in between.
- R12: With channel 1 cascaded on channel 0, load values L0 and L1 give a flag on channel 1 (and `irq` when enabled) after exactly (L0+1)·(L1+1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe shared by all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined timeout interrupt |

## Verification
The bench checks the count one tick before expiry and again at expiry. A design with an off-by-one period or one that reloads with a stale value shows the wrong flag or count at one of those two points. It also rewrites the load value mid-period, where a design that copies the value straight into the counter is visibly off. For the cascaded pair it samples the upper flag one tick short of the product period and at the full period, and it checks that the upper count holds while the lower channel steps. The lifetime test lets the low channel reload between the high and low reads, which exposes a low half read live instead of latched. A cascade bit honoured on channel 0 would leave that channel frozen.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int unsigned OFF_LOAD = 0;
  localparam int unsigned OFF_CVAL = 1;
  localparam int unsigned OFF_CTRL = 2;
  localparam int unsigned OFF_FLAG = 3;
  localparam int unsigned REGS_PER_CH = 4;

  typedef struct packed {
    logic cascade;
    logic irq_en;
    logic run;
  } chan_ctrl_t;

  function automatic int unsigned chan_reg(input int unsigned ch, input int unsigned off);
    return ch * REGS_PER_CH + off;
  endfunction

endpackage

// File: rtl/ptmr_chan.sv
module ptmr_chan #(
  parameter int CW        = 32,
  parameter bit HAS_LOWER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          run,
  input  logic          cascade,
  input  logic          tick,
  input  logic          carry_in,
  input  logic [CW-1:0] load_val,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          expire
);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] ld);
    return (cur == '0) ? ld : cur - 1'b1;
  endfunction

  logic active, was_act, start, dec, eff_casc;

  assign eff_casc = HAS_LOWER ? cascade : 1'b0;
  assign active   = go & run;
  assign start    = active & ~was_act;
  assign dec      = active & was_act & (eff_casc ? carry_in : tick);
  assign expire   = dec & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_act <= 1'b0;
      cnt     <= '0;
      flag    <= 1'b0;
    end else begin
      was_act <= active;
      if (start)    cnt <= load_val;
      else if (dec) cnt <= next_count(cnt, load_val);
      if (expire)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(load_val));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && was_act && !eff_casc && !tick) |=> $stable(cnt));
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  p_casc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && was_act && eff_casc && !carry_in) |=> $stable(cnt));
  p_off_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cnt));
  p_start_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(load_val));

endmodule

// File: rtl/ptmr_snap.sv
module ptmr_snap #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [CW-1:0] lo_live,
  output logic [CW-1:0] snap
);

  always_ff @(posedge clk) begin
    if (!rst_n)   snap <= '0;
    else if (cap) snap <= lo_live;
  end

  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(snap));

endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank #(
  parameter int NUM_CH = 4,
  parameter int CW     = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              irq
);
  import ptmr_pkg::*;

  localparam logic [ADDR_W-1:0] A_HALT = ADDR_W'(NUM_CH * REGS_PER_CH);
  localparam logic [ADDR_W-1:0] A_LTHI = ADDR_W'(NUM_CH * REGS_PER_CH + 1);
  localparam logic [ADDR_W-1:0] A_LTLO = ADDR_W'(NUM_CH * REGS_PER_CH + 2);

  logic [CW-1:0]     load_q [NUM_CH];
  chan_ctrl_t        ctrl_q [NUM_CH];
  logic [CW-1:0]     cval_v [NUM_CH];
  logic [NUM_CH-1:0] flag_v, exp_v, ie_v, clr_v;
  logic              halt_q;
  logic [CW-1:0]     rd_mux, snap;
  logic              lt_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        load_q[i] <= '0;
        ctrl_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (addr == A_HALT) halt_q <= wdata[0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(chan_reg(i, OFF_LOAD))) load_q[i] <= wdata;
        if (addr == ADDR_W'(chan_reg(i, OFF_CTRL))) ctrl_q[i] <= chan_ctrl_t'(wdata[2:0]);
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic carry;
    if (g == 0) begin : g_base
      assign carry = 1'b0;
    end else begin : g_up
      assign carry = exp_v[g-1];
    end
    assign clr_v[g] = wr_en && (addr == ADDR_W'(chan_reg(g, OFF_FLAG))) && wdata[0];
    assign ie_v[g]  = ctrl_q[g].irq_en;

    ptmr_chan #(.CW(CW), .HAS_LOWER(g != 0)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (~halt_q),
      .run      (ctrl_q[g].run),
      .cascade  (ctrl_q[g].cascade),
      .tick     (tick),
      .carry_in (carry),
      .load_val (load_q[g]),
      .flag_clr (clr_v[g]),
      .cnt      (cval_v[g]),
      .flag     (flag_v[g]),
      .expire   (exp_v[g])
    );
  end

  assign lt_cap = rd_en && (addr == A_LTHI);

  ptmr_snap #(.CW(CW)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (lt_cap),
    .lo_live (cval_v[0]),
    .snap    (snap)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(chan_reg(i, OFF_LOAD))) rd_mux = load_q[i];
      if (addr == ADDR_W'(chan_reg(i, OFF_CVAL))) rd_mux = cval_v[i];
      if (addr == ADDR_W'(chan_reg(i, OFF_CTRL))) rd_mux = CW'(ctrl_q[i]);
      if (addr == ADDR_W'(chan_reg(i, OFF_FLAG))) rd_mux = CW'(flag_v[i]);
    end
    if (addr == A_HALT) rd_mux = CW'(halt_q);
    if (addr == A_LTHI) rd_mux = cval_v[1];
    if (addr == A_LTLO) rd_mux = snap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = |(flag_v & ie_v);

  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_v == '0) |-> !irq);
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v == '0) |-> !irq);
  p_halt_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (exp_v == '0));

endmodule

// File: tb/cascade_timer_bank_tb.sv
module cascade_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  cascade_timer_bank u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [5:0] ra(input int ch, input int kind);
    return 6'(kind + 4 * ch);
  endfunction
  localparam int LD = 0, CV = 1, CT = 2, FL = 3;
  localparam logic [5:0] HALT = 6'd16, LTHI = 6'd17, LTLO = 6'd18;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) begin
      rchk("R1 load", ra(c, LD), 0);
      rchk("R1 ctrl", ra(c, CT), 0);
      rchk("R1 flag", ra(c, FL), 0);
    end
    rchk("R1 halt", HALT, 1);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_halt;
    wr(ra(2, LD), 3); wr(ra(2, CT), 1); idle(2); tk(5);
    rchk("R8 no flag while halted", ra(2, FL), 0);
    rchk("R8 no count while halted", ra(2, CV), 0);
    wr(HALT, 0); idle(2);
    rchk("R8 load on release", ra(2, CV), 3);
  endtask

  task automatic t_period;
    tk(3);
    rchk("R2 count before expiry", ra(2, CV), 0);
    rchk("R2 no flag before expiry", ra(2, FL), 0);
    tk(1);
    rchk("R2 flag at expiry", ra(2, FL), 1);
    rchk("R2 reload", ra(2, CV), 3);
    wr(ra(2, FL), 1); tk(4);
    rchk("R2 second period", ra(2, FL), 1);
    wr(ra(2, FL), 1);
  endtask

  task automatic t_notick;
    tk(1); idle(10);
    rchk("R3 holds without tick", ra(2, CV), 2);
    tk(3);
  endtask

  task automatic t_flag;
    tk(4);
    rchk("R4 flag sticky", ra(2, FL), 1);
    wr(ra(2, FL), 0);
    rchk("R4 write 0 ignored", ra(2, FL), 1);
    wr(ra(2, FL), 1);
    rchk("R4 write 1 clears", ra(2, FL), 0);
  endtask

  task automatic t_irq;
    tk(4);
    chk("R5 irq off without enable", 32'(irq), 0);
    wr(ra(2, CT), 3);
    chk("R5 irq on", 32'(irq), 1);
    wr(ra(2, FL), 1);
    chk("R5 irq off after clear", 32'(irq), 0);
  endtask

  task automatic t_loadupd;
    wr(ra(2, LD), 5); tk(1);
    rchk("R10 count undisturbed", ra(2, CV), 2);
    tk(2);
    rchk("R10 old period", ra(2, FL), 0);
    tk(1);
    rchk("R10 new load at reload", ra(2, CV), 5);
    wr(ra(2, FL), 1);
  endtask

  task automatic t_ctrl0;
    wr(ra(2, CT), 0);
    rchk("R9 ctrl reads 0", ra(2, CT), 0);
    tk(10);
    rchk("R9 stopped no flag", ra(2, FL), 0);
    chk("R9 irq low", 32'(irq), 0);
    wr(ra(2, CT), 1); idle(2);
    rchk("R9 restart loads", ra(2, CV), 5);
    wr(ra(2, CT), 0);
  endtask

  task automatic t_ch0casc;
    wr(ra(0, LD), 1); wr(ra(0, CT), 5); idle(2);
    tk(1);
    rchk("R7 ch0 counts on tick", ra(0, CV), 0);
    tk(1);
    rchk("R7 ch0 expires", ra(0, FL), 1);
    wr(ra(0, CT), 0); wr(ra(0, FL), 1);
  endtask

  task automatic t_casc;
    wr(ra(0, LD), 2); wr(ra(1, LD), 1);
    wr(ra(1, CT), 7); wr(ra(0, CT), 1); idle(2);
    tk(2);
    rchk("R6 upper holds", ra(1, CV), 1);
    tk(1);
    rchk("R6 upper steps on lower expiry", ra(1, CV), 0);
    tk(2);
    rchk("R12 no flag one short", ra(1, FL), 0);
    chk("R12 irq low one short", 32'(irq), 0);
    tk(1);
    rchk("R12 flag at full period", ra(1, FL), 1);
    chk("R12 irq at full period", 32'(irq), 1);
    wr(ra(1, FL), 1); wr(ra(0, FL), 1);
  endtask

  task automatic t_life;
    tk(1);
    rchk("R11 high half", LTHI, 1);
    tk(2);
    rchk("R11 latched low", LTLO, 1);
    rchk("R11 live low moved", ra(0, CV), 2);
    rchk("R11 high after roll", LTHI, 0);
    rchk("R11 low after roll", LTLO, 2);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_halt; t_period; t_notick; t_flag; t_irq;
    t_loadupd; t_ctrl0; t_ch0casc; t_casc; t_life;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule